// File: doc/BRIEF.md
# HDLC Receive Line Status Monitor

This block watches the serial receive data line of an HDLC link, one bit per bit-clock enable, and tracks the line's present condition. It shows two live status bits. One says that flag octets are arriving. The other says that the line has gone idle. It also emits single-cycle event pulses in the system clock domain whenever something changes on the line: flag reception starting or stopping, the line going idle, a frame closing, and a receive buffer filling up.

Flags are found by sliding an 8-bit window over the incoming bits. Octets between flags are counted to judge whether a closing flag ends a real frame, and to pace the buffer-full events against a buffer length that can be set at run time. Zero-bit removal, CRC checking, buffer storage and modem-control signals belong elsewhere in the receiver. The monitor only observes the line.

Top module: `hdlc_rx_line_monitor`

## Requirements
- R1: While reset is asserted, `status` reads 8'h00 and no event output is high.
- R2: `status` bit 7 is the idle bit and bit 6 is the flag bit. Bits 5 to 0 always read zero.
- R3: A flag is the pattern 0,1,1,1,1,1,1,0, seen in the eight most recent sampled bits (oldest first), with bits before reset counted as zero. The flag bit is set by a flag. It stays set while every window of eight bits after the latest flag still contains a flag. It clears on the eighth bit after the latest flag if that bit does not complete another flag.
- R4: `ev_flag` pulses when the flag bit goes from 0 to 1 and when it goes from 1 to 0. An unbroken run of flags therefore gives exactly two pulses.
- R5: On the 15th consecutive one bit, the idle bit sets and `ev_idle` pulses once. Further ones keep the idle bit set and give no new pulse.
- R6: A received zero bit clears the idle bit.
- R7: After a flag, every 8 bits that do not end in a flag count as one octet. A flag that arrives after at least 5 counted octets, with no abort since the previous flag, pulses `ev_frame`. A flag with fewer octets before it gives no `ev_frame`.
- R8: Inside a frame, `ev_buf` pulses each time the octet count since the last flag, or since the last buffer event, reaches `buf_size`. Each flag restarts this count. A `buf_size` of 0 gives no buffer events.
- R9: A run of 7 or more ones aborts the frame in progress. Octets that follow are not counted, and no `ev_frame` or `ev_buf` occurs until a flag has been seen again.
- R10: An event pulse appears in the system cycle that follows a cycle with `bit_en` high, and lasts one cycle. In a cycle after `bit_en` was low, the status does not change and no event is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_en | input | 1 | Receive bit-clock enable; `rxd` is sampled when high |
| rxd | input | 1 | Serial receive data |
| buf_size | input | SZ_W | Receive buffer length in octets; 0 disables buffer events |
| status | output | 8 | Read-only status: bit 7 idle, bit 6 flag |
| ev_flag | output | 1 | Pulse at start and end of flag reception |
| ev_idle | output | 1 | Pulse when 15 consecutive ones have arrived |
| ev_frame | output | 1 | Pulse at the closing flag of a frame |
| ev_buf | output | 1 | Pulse when a receive buffer fills |

## Verification
The bench builds the block with its default parameters: idle after 15 ones, abort at 7 ones, a 5-octet minimum frame and an 8-bit buffer size. At run time it sets `buf_size` to 6, 3 and 0. With 6, an 8-octet frame gives one mid-frame buffer event. With 3, it gives repeated events within one frame. With 0, the events are disabled. The stimulus also includes short frames, an aborted frame that resumes without a flag, and runs of idle ones long enough to pass the 15-bit threshold. These reach the sync-loss and minimum-length paths as well as the idle threshold.

// File: rtl/hdlc_rx_line_monitor.sv
module hdlc_rx_line_monitor #(
  parameter int IDLE_RUN  = 15,
  parameter int ABORT_RUN = 7,
  parameter int MIN_BYTES = 5,
  parameter int SZ_W      = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_en,
  input  logic            rxd,
  input  logic [SZ_W-1:0] buf_size,
  output logic [7:0]      status,
  output logic            ev_flag,
  output logic            ev_idle,
  output logic            ev_frame,
  output logic            ev_buf
);

  localparam int RUN_W = $clog2(IDLE_RUN + 1);
  localparam int FC_W  = $clog2(MIN_BYTES + 1);
  localparam logic [7:0] FLAG_PAT = 8'h7E;
  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(IDLE_RUN);
  localparam logic [RUN_W-1:0] RUN_PRE  = RUN_W'(IDLE_RUN - 1);
  localparam logic [RUN_W-1:0] RUN_ABRT = RUN_W'(ABORT_RUN);
  localparam logic [FC_W-1:0]  FC_MIN   = FC_W'(MIN_BYTES);

  logic [6:0]       hist;
  logic [RUN_W-1:0] run, run_nxt;
  logic             idle_q, flag_q, synced;
  logic [2:0]       bitpos;
  logic [FC_W-1:0]  fcnt;
  logic [SZ_W-1:0]  fill;
  logic             hit, idle_hit, flag_end, byte_done, frame_hit, buf_hit, abort_run;

  assign hit       = ({hist, rxd} == FLAG_PAT);
  assign run_nxt   = !rxd ? '0 : (run == RUN_MAX) ? run : run + 1'b1;
  assign idle_hit  = rxd && (run == RUN_PRE);
  assign abort_run = rxd && (run_nxt >= RUN_ABRT);
  assign flag_end  = flag_q && !hit && (bitpos == 3'd7);
  assign byte_done = synced && !hit && (bitpos == 3'd7);
  assign frame_hit = hit && synced && (fcnt >= FC_MIN);
  assign buf_hit   = byte_done && (buf_size != '0) && (fill + SZ_W'(1) == buf_size);
  assign status    = {idle_q, flag_q, 6'b0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist   <= '0;
      run    <= '0;
      idle_q <= 1'b0;
      flag_q <= 1'b0;
      synced <= 1'b0;
      bitpos <= '0;
      fcnt   <= '0;
      fill   <= '0;
    end else if (bit_en) begin
      hist   <= {hist[5:0], rxd};
      run    <= run_nxt;
      bitpos <= hit ? 3'd0 : bitpos + 3'd1;
      if (!rxd) idle_q <= 1'b0;
      else if (idle_hit) idle_q <= 1'b1;
      if (hit) flag_q <= 1'b1;
      else if (flag_end) flag_q <= 1'b0;
      if (hit) synced <= 1'b1;
      else if (abort_run) synced <= 1'b0;
      if (hit || !synced) begin
        fcnt <= '0;
        fill <= '0;
      end else if (byte_done) begin
        if (fcnt != FC_MIN) fcnt <= fcnt + 1'b1;
        fill <= buf_hit ? '0 : fill + SZ_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_flag  <= 1'b0;
      ev_idle  <= 1'b0;
      ev_frame <= 1'b0;
      ev_buf   <= 1'b0;
    end else begin
      ev_flag  <= bit_en && ((hit && !flag_q) || flag_end);
      ev_idle  <= bit_en && idle_hit;
      ev_frame <= bit_en && frame_hit;
      ev_buf   <= bit_en && buf_hit;
    end
  end

  AST_IDLE_EV_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle |-> status[7]) else $error("idle event without idle bit"); // R5

  AST_ZERO_CLEARS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && !rxd) |=> !status[7]) else $error("idle bit survived a zero"); // R6

  AST_FLAG_EV_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag |-> (status[6] != $past(status[6]))) else $error("flag event without flag bit change"); // R4

  AST_FRAME_ON_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ev_frame |-> (status[6] && !ev_buf)) else $error("frame event off a flag"); // R7

  AST_QUIET_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> ($stable(status) && !ev_flag && !ev_idle && !ev_frame && !ev_buf))
    else $error("activity without a bit"); // R10

endmodule

// File: tb/hdlc_rx_line_monitor_test.sv
module hdlc_rx_line_monitor_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rxd = 1'b1;
  logic [7:0] buf_size = 8'd6;
  logic [7:0] status;
  logic ev_flag, ev_idle, ev_frame, ev_buf;

  hdlc_rx_line_monitor uut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rxd(rxd), .buf_size(buf_size),
    .status(status), .ev_flag(ev_flag), .ev_idle(ev_idle), .ev_frame(ev_frame), .ev_buf(ev_buf)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  bit q_bits[$];
  int tr = 0, last_hit = -1, nbytes = 0;
  bit bad = 1'b0;
  bit x_flag = 0, x_idle = 0, e_flag = 0, e_idle = 0, e_frame = 0, e_buf = 0;
  int obs_flag = 0, obs_frame = 0, obs_buf = 0, obs_idle = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 status low bits", int'(status[5:0]), 0);
    chk("R3 flag bit", int'(status[6]), int'(x_flag));
    chk("R5/R6 idle bit", int'(status[7]), int'(x_idle));
    chk("R4 ev_flag", int'(ev_flag), int'(e_flag));
    chk("R5 ev_idle", int'(ev_idle), int'(e_idle));
    chk("R7 ev_frame", int'(ev_frame), int'(e_frame));
    chk("R8 ev_buf", int'(ev_buf), int'(e_buf));
    obs_flag += int'(ev_flag);
    obs_frame += int'(ev_frame);
    obs_buf += int'(ev_buf);
    obs_idle += int'(ev_idle);
  endtask

  task automatic model(input bit b);
    int n;
    logic [7:0] win;
    bit hit, nf;
    q_bits.push_back(b);
    n = q_bits.size() - 1;
    win = '0;
    for (int i = n - 7; i <= n; i++) win = {win[6:0], (i < 0) ? 1'b0 : q_bits[i]};
    hit = (win == 8'h7E);
    tr = b ? tr + 1 : 0;
    e_idle = (tr == 15);
    x_idle = (tr >= 15);
    e_buf = 0;
    e_frame = 0;
    if (!hit && last_hit >= 0 && ((n - last_hit) % 8 == 0) && !bad) begin
      nbytes++;
      if (buf_size != 0 && (nbytes % int'(buf_size)) == 0) e_buf = 1;
    end
    if (hit && last_hit >= 0 && !bad && nbytes >= 5) e_frame = 1;
    if (tr >= 7) bad = 1;
    if (hit) begin
      last_hit = n;
      nbytes = 0;
      bad = 0;
    end
    nf = (last_hit >= 0) && (n - last_hit <= 7);
    e_flag = (nf != x_flag);
    x_flag = nf;
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk);
    rxd = b;
    bit_en = 1'b1;
    model(b);
    @(negedge clk);
    check_all();
    bit_en = 1'b0;
    e_flag = 0; e_idle = 0; e_frame = 0; e_buf = 0;
    @(negedge clk);
    check_all();   // R10 quiet cycle
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
  endtask

  task automatic send_ones(input int k);
    for (int i = 0; i < k; i++) send_bit(1'b1);
  endtask

  task automatic send_frame(input int len);
    logic [7:0] pool [8] = '{8'h21, 8'h03, 8'h13, 8'h45, 8'h22, 8'h18, 8'h5A, 8'hC3};
    send_byte(8'h7E);
    for (int i = 0; i < len; i++) send_byte(pool[i % 8]);
    send_byte(8'h7E);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int f0, b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 status in reset", int'(status), 0);
      chk("R1 events in reset", int'({ev_flag, ev_idle, ev_frame, ev_buf}), 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();

    send_ones(20);
    chk("R5 single idle pulse", obs_idle, 1);

    f0 = obs_flag;
    send_byte(8'h7E); send_byte(8'h7E); send_byte(8'h7E);
    send_byte(8'h21);
    chk("R4 two flag pulses per run", obs_flag - f0, 2);

    buf_size = 8'd6;
    f0 = obs_frame; b0 = obs_buf;
    send_frame(8);
    send_byte(8'h7E);
    send_ones(16);
    chk("R7 full frame", obs_frame - f0, 1);
    chk("R8 one buffer event size 6", obs_buf - b0, 1);

    f0 = obs_frame;
    send_frame(3);
    send_ones(10);
    chk("R7 short frame ignored", obs_frame - f0, 0);

    f0 = obs_frame; b0 = obs_buf;
    send_byte(8'h7E);
    send_byte(8'h21); send_byte(8'h03);
    send_ones(8);
    send_byte(8'h13); send_byte(8'h45); send_byte(8'h22);
    send_byte(8'h18); send_byte(8'h5A); send_byte(8'h03);
    send_byte(8'h7E);
    chk("R9 aborted frame", obs_frame - f0, 0);
    chk("R9 no buffer after abort", obs_buf - b0, 0);

    buf_size = 8'd3;
    f0 = obs_frame; b0 = obs_buf;
    send_frame(7);
    send_ones(9);
    chk("R8 buffer events size 3", obs_buf - b0, 2);
    chk("R7 frame size 3 run", obs_frame - f0, 1);

    buf_size = 8'd0;
    f0 = obs_frame; b0 = obs_buf;
    send_frame(6);
    send_ones(20);
    chk("R8 size 0 disables", obs_buf - b0, 0);
    chk("R7 frame with size 0", obs_frame - f0, 1);
    chk("R5 idle after trailing ones", int'(status[7]), 1);

    send_bit(1'b0);
    chk("R6 zero clears idle", int'(status[7]), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule